// File: doc/BRIEF.md
# Fixed-Length Instruction Sequencer

This block is the control unit of a small 8-bit accumulator machine that addresses a 256-byte memory. It keeps the program counter and the instruction register, decodes the opcode, and walks a 3-bit step counter through exactly eight steps per instruction. In each step it raises the strobes the datapath needs: the memory-address source select, the address-register load, memory read and write, the data-register load, the accumulator load with an ALU operation code, and the PC increment and PC load. The ALU, the accumulator, the address and data registers and the memory array belong to the surrounding datapath. That datapath is expected to put the data register on the data bus, which this unit samples.

Steps 0 to 2 are the same for every instruction and fetch the opcode byte. The opcode is the upper nibble of that byte, and a one-hot decode of it selects the pattern for steps 3 to 7. A conditional jump uses the unconditional-jump pattern when its flag is set. When the flag is clear it uses an idle pattern that only steps the PC past the address byte. A halt instruction freezes the unit until reset.

Top module: `seqc_top`

## Requirements
- R1: While reset is asserted and right after its release, `pc` is 0, `step` is 0 and `halted` is 0.
- R2: `step` advances by one per clock and wraps from 7 to 0, so every non-halting instruction occupies exactly eight clocks.
- R3: Steps 0 to 2 of every instruction are the fetch. Step 0 drives `mar_ld` with `addr_sel`=0. Step 1 drives `mem_rd`, `mdr_ld` and `pc_inc`. Step 2 drives no strobe, and the instruction register captures `data_bus` on that step.
- R4: Only bits 7:4 of the instruction byte are decoded. The codes are NOP 0x0, STA 0x1, LDA 0x2, ADD 0x3, OR 0x4, AND 0x5, NOT 0x6, JMP 0x8, JN 0x9, JZ 0xA and HLT 0xF. Any other code behaves as NOP, which raises no strobe in steps 3 to 7.
- R5: LDA, ADD, OR and AND follow the same pattern. Step 3 drives `mar_ld` (`addr_sel`=0). Step 4 drives `mem_rd`, `mdr_ld` and `pc_inc`. Step 5 drives `mar_ld` with `addr_sel`=1. Step 6 drives `mem_rd` and `mdr_ld`. Step 7 drives `acc_ld`, with `alu_op` set to 1 for LDA (pass), 2 for ADD, 3 for OR and 4 for AND. `alu_op` is 0 whenever `acc_ld` is low.
- R6: STA matches R5 in steps 3 to 5. In step 6 it drives only `mem_wr`, and in step 7 it drives nothing.
- R7: NOT drives `acc_ld` with `alu_op`=5 in step 3 and nothing else in steps 3 to 7.
- R8: JMP drives `mar_ld` in step 3 and `mem_rd` with `mdr_ld` in step 4. In step 5 it drives `pc_ld`, which loads `pc` from `data_bus`.
- R9: JN with `flag_neg`=1, and JZ with `flag_zero`=1, follow the JMP pattern. Otherwise they drive only `pc_inc`, in step 3, so execution resumes after the address byte.
- R10: HLT raises no strobe. From the clock after its step 3, `halted` is 1, `step` stays 3, `pc` stays unchanged and every strobe stays low until reset.
- R11: `pc` changes only on a clock where `pc_inc` (+1) or `pc_ld` (load) is high.
- R12: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_bus | input | 8 | Datapath data bus (data register contents) |
| flag_neg | input | 1 | Accumulator negative flag |
| flag_zero | input | 1 | Accumulator zero flag |
| addr_sel | output | 1 | Address source: 0 = PC, 1 = data bus |
| mar_ld | output | 1 | Load memory address register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mdr_ld | output | 1 | Load memory data register |
| acc_ld | output | 1 | Load accumulator from ALU |
| alu_op | output | 3 | ALU operation, see R5 and R7 |
| pc_inc | output | 1 | Increment PC |
| pc_ld | output | 1 | Load PC from data bus |
| pc | output | 8 | Program counter |
| step | output | 3 | Current time step |
| halted | output | 1 | Halt state |

## Verification
The bench runs two programs through a small memory model. The first runs with both flags clear. It chains every memory-operand instruction, NOT, STA, a defined NOP, an undefined code, an opcode byte with nonzero low bits, an unconditional jump and two skipped conditional jumps, then halts. This separates the per-opcode step patterns and shows that the skip path steps over the address byte. The second run sets both flags. It follows taken JN and JZ jumps and a JMP whose low nibble is nonzero, then halts. This shows that the flag, not the opcode alone, selects the jump pattern, and that the halt freeze holds at a different PC.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

   localparam int NUM_INSN = 11;

   // one-hot instruction line positions
   typedef enum int unsigned {
      L_NOP = 0, L_STA, L_LDA, L_ADD, L_OR, L_AND, L_NOT, L_JMP, L_JN, L_JZ, L_HLT
   } line_e;

   // opcode nibble matched by each decoded line
   function automatic logic [3:0] line_code(input int unsigned idx);
      case (idx)
         1:       return 4'h1;
         2:       return 4'h2;
         3:       return 4'h3;
         4:       return 4'h4;
         5:       return 4'h5;
         6:       return 4'h6;
         7:       return 4'h8;
         8:       return 4'h9;
         9:       return 4'hA;
         10:      return 4'hF;
         default: return 4'h0;
      endcase
   endfunction

   typedef enum logic [2:0] {
      ALU_IDLE = 3'd0, ALU_PASS = 3'd1, ALU_ADD = 3'd2,
      ALU_OR   = 3'd3, ALU_AND  = 3'd4, ALU_NOT = 3'd5
   } alu_op_e;

   typedef struct packed {
      logic    addr_sel;
      logic    mar_ld;
      logic    mem_rd;
      logic    mem_wr;
      logic    mdr_ld;
      logic    acc_ld;
      alu_op_e alu_op;
      logic    pc_inc;
      logic    pc_ld;
      logic    ir_ld;
      logic    halt_now;
   } strobe_t;

endpackage

// File: rtl/seqc_step_ctr.sv
module seqc_step_ctr #(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   output logic [STEP_W-1:0] step
);

   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     step_q <= '0;
      else if (!hold) step_q <= step_q + 1'b1;
   end

   assign step = step_q;

   // R2
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> step_q == STEP_W'($past(step_q) + 1'b1));

   // R10
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(step_q));

endmodule

// File: rtl/seqc_decoder.sv
module seqc_decoder
   import seqc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]   ir_byte,
   output logic [NUM_INSN-1:0] lines
);

   localparam int OPC_W = 4;

   logic [OPC_W-1:0]    opc;
   logic [NUM_INSN-1:0] hit;

   assign opc = ir_byte[DATA_W-1 -: OPC_W];

   for (genvar i = 0; i < NUM_INSN; i++) begin : g_match
      assign hit[i] = (opc == line_code(i));
   end

   // anything not matched by a defined line falls back to NOP
   assign lines[NUM_INSN-1:1] = hit[NUM_INSN-1:1];
   assign lines[0]            = ~|hit[NUM_INSN-1:1];

endmodule

// File: rtl/seqc_pc_reg.sv
module seqc_pc_reg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              ld,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] pc
);

   logic [ADDR_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   pc_q <= '0;
      else if (ld)  pc_q <= d;
      else if (inc) pc_q <= pc_q + 1'b1;
   end

   assign pc = pc_q;

   // R11
   pc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc || ld) |=> $stable(pc_q));

endmodule

// File: rtl/seqc_strobe_gen.sv
module seqc_strobe_gen
   import seqc_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  logic [STEP_W-1:0]   step,
   input  logic [NUM_INSN-1:0] lines,
   input  logic                flag_neg,
   input  logic                flag_zero,
   output strobe_t             strb
);

   logic    memop, take, skip;
   alu_op_e mem_alu;

   assign memop = lines[L_STA] | lines[L_LDA] | lines[L_ADD] | lines[L_OR] | lines[L_AND];
   assign take  = lines[L_JMP] | (lines[L_JN] & flag_neg) | (lines[L_JZ] & flag_zero);
   assign skip  = (lines[L_JN] | lines[L_JZ]) & ~take;

   always_comb begin
      mem_alu = ALU_IDLE;
      if (lines[L_LDA]) mem_alu = ALU_PASS;
      if (lines[L_ADD]) mem_alu = ALU_ADD;
      if (lines[L_OR])  mem_alu = ALU_OR;
      if (lines[L_AND]) mem_alu = ALU_AND;
   end

   always_comb begin
      strb = '0;
      case (step)
         STEP_W'(0): strb.mar_ld = 1'b1;
         STEP_W'(1): begin
            strb.mem_rd = 1'b1;
            strb.mdr_ld = 1'b1;
            strb.pc_inc = 1'b1;
         end
         STEP_W'(2): strb.ir_ld = 1'b1;
         STEP_W'(3): begin
            strb.mar_ld   = memop | take;
            strb.pc_inc   = skip;
            strb.acc_ld   = lines[L_NOT];
            strb.alu_op   = lines[L_NOT] ? ALU_NOT : ALU_IDLE;
            strb.halt_now = lines[L_HLT];
         end
         STEP_W'(4): begin
            strb.mem_rd = memop | take;
            strb.mdr_ld = memop | take;
            strb.pc_inc = memop;
         end
         STEP_W'(5): begin
            strb.addr_sel = memop;
            strb.mar_ld   = memop;
            strb.pc_ld    = take;
         end
         STEP_W'(6): begin
            strb.mem_wr = lines[L_STA];
            strb.mem_rd = memop & ~lines[L_STA];
            strb.mdr_ld = memop & ~lines[L_STA];
         end
         STEP_W'(7): begin
            strb.acc_ld = memop & ~lines[L_STA];
            strb.alu_op = mem_alu;
         end
         default: strb = '0;
      endcase
   end

endmodule

// File: rtl/seqc_top.sv
module seqc_top
   import seqc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int STEPS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_bus,
   input  logic              flag_neg,
   input  logic              flag_zero,
   output logic              addr_sel,
   output logic              mar_ld,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mdr_ld,
   output logic              acc_ld,
   output logic [2:0]        alu_op,
   output logic              pc_inc,
   output logic              pc_ld,
   output logic [ADDR_W-1:0] pc,
   output logic [2:0]        step,
   output logic              halted
);

   localparam int STEP_W = $clog2(STEPS);

   if (STEPS != 8) begin : g_bad_steps
      $error("seqc_top: the step schedule is written for exactly 8 steps");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("seqc_top: DATA_W must hold a 4-bit opcode");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("seqc_top: an address must fit in one data byte");
   end

   logic [DATA_W-1:0]   ir_q;
   logic                halted_q;
   logic [NUM_INSN-1:0] dec_lines;
   logic [STEP_W-1:0]   step_w;
   strobe_t             strb, strb_g;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_q     <= '0;
         halted_q <= 1'b0;
      end else begin
         if (strb_g.ir_ld)    ir_q     <= data_bus;
         if (strb_g.halt_now) halted_q <= 1'b1;
      end
   end

   assign strb_g = halted_q ? '0 : strb;

   seqc_step_ctr #(.STEP_W(STEP_W)) i_step (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (halted_q | strb.halt_now),
      .step  (step_w)
   );

   seqc_decoder #(.DATA_W(DATA_W)) i_dec (
      .ir_byte (ir_q),
      .lines   (dec_lines)
   );

   seqc_strobe_gen #(.STEP_W(STEP_W)) i_gen (
      .step      (step_w),
      .lines     (dec_lines),
      .flag_neg  (flag_neg),
      .flag_zero (flag_zero),
      .strb      (strb)
   );

   seqc_pc_reg #(.ADDR_W(ADDR_W)) i_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (strb_g.pc_inc),
      .ld    (strb_g.pc_ld),
      .d     (data_bus[ADDR_W-1:0]),
      .pc    (pc)
   );

   assign addr_sel = strb_g.addr_sel;
   assign mar_ld   = strb_g.mar_ld;
   assign mem_rd   = strb_g.mem_rd;
   assign mem_wr   = strb_g.mem_wr;
   assign mdr_ld   = strb_g.mdr_ld;
   assign acc_ld   = strb_g.acc_ld;
   assign alu_op   = strb_g.alu_op;
   assign pc_inc   = strb_g.pc_inc;
   assign pc_ld    = strb_g.pc_ld;
   assign step     = 3'(step_w);
   assign halted   = halted_q;

   // R4
   dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dec_lines) == 1);

   // R12
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R3
   fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step < 3'd3) |-> !(pc_ld || mem_wr || acc_ld));

   // R10
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc) && $stable(step) && halted);

   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !(mar_ld || mem_rd || mem_wr || mdr_ld || acc_ld || pc_inc || pc_ld));

endmodule

// File: tb/test_seqc_top.sv
`timescale 1ns/1ps
module test_seqc_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] data_bus;
   logic       flag_neg = 1'b0, flag_zero = 1'b0;
   logic       addr_sel, mar_ld, mem_rd, mem_wr, mdr_ld, acc_ld, pc_inc, pc_ld, halted;
   logic [2:0] alu_op, step;
   logic [7:0] pc;

   always #2.5 clk = ~clk;

   seqc_top i_seqc_top (
      .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .flag_neg(flag_neg),
      .flag_zero(flag_zero), .addr_sel(addr_sel), .mar_ld(mar_ld), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mdr_ld(mdr_ld), .acc_ld(acc_ld), .alu_op(alu_op),
      .pc_inc(pc_inc), .pc_ld(pc_ld), .pc(pc), .step(step), .halted(halted)
   );

   // datapath model: address register, data register, memory
   logic [7:0] mem [256];
   logic [7:0] mar, mdr;
   assign data_bus = mdr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar <= '0;
         mdr <= '0;
      end else begin
         if (mar_ld)           mar <= addr_sel ? data_bus : pc;
         if (mem_rd && mdr_ld) mdr <= mem[mar];
      end
   end

   typedef struct {
      logic [7:0] ib;
      logic [7:0] pc_after;
   } item_t;

   item_t q[$];
   int    vectors = 0, miscompares = 0;
   logic [7:0] wp;
   bit    done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   // expected strobe vector {addr_sel,mar_ld,mem_rd,mem_wr,mdr_ld,acc_ld,alu_op,pc_inc,pc_ld}
   function automatic logic [10:0] exp_strb(input logic [7:0] ib, input int k);
      logic [3:0] n;
      logic       memop, tk, sk;
      n     = ib[7:4];
      memop = (n >= 4'h1 && n <= 4'h5);
      tk    = (n == 4'h8) || (n == 4'h9 && flag_neg) || (n == 4'hA && flag_zero);
      sk    = (n == 4'h9 || n == 4'hA) && !tk;
      case (k)
         0: return 11'b0100_0000_000;
         1: return 11'b0010_1000_010;
         2: return 11'b0;
         3: if (memop || tk) return 11'b0100_0000_000;
            else if (sk)     return 11'b0000_0000_010;
            else if (n == 4'h6) return {6'b000001, 3'd5, 2'b00};
            else return 11'b0;
         4: if (memop) return 11'b0010_1000_010;
            else if (tk) return 11'b0010_1000_000;
            else return 11'b0;
         5: if (memop) return 11'b1100_0000_000;
            else if (tk) return 11'b0000_0000_001;
            else return 11'b0;
         6: if (n == 4'h1) return 11'b0001_0000_000;
            else if (memop) return 11'b0010_1000_000;
            else return 11'b0;
         default: if (memop && n != 4'h1) return {6'b000001, 3'(n - 4'h1), 2'b00};
                  else return 11'b0;
      endcase
   endfunction

   function automatic string tag_for(input logic [7:0] ib, input int k);
      if (k < 3) return "R3";
      case (ib[7:4])
         4'h1: return "R6";
         4'h2, 4'h3, 4'h4, 4'h5: return "R5";
         4'h6: return "R7";
         4'h8: return "R8";
         4'h9, 4'hA: return "R9";
         4'hF: return "R10";
         default: return "R4";
      endcase
   endfunction

   // driver: lay down one instruction along the flow and push its expectation
   task automatic emit(input logic [7:0] ib, input logic [7:0] arg);
      item_t      it;
      logic [3:0] n;
      int         len;
      logic       tk;
      n   = ib[7:4];
      len = ((n >= 4'h1 && n <= 4'h5) || n == 4'h8 || n == 4'h9 || n == 4'hA) ? 2 : 1;
      tk  = (n == 4'h8) || (n == 4'h9 && flag_neg) || (n == 4'hA && flag_zero);
      mem[wp] = ib;
      if (len == 2) mem[8'(wp + 1)] = arg;
      it.ib       = ib;
      it.pc_after = tk ? arg : 8'(wp + len);
      q.push_back(it);
      wp = it.pc_after;
   endtask

   // monitor: follow the DUT step by step at negedges
   task automatic run_monitor();
      item_t it;
      logic [10:0] act;
      while (q.size() > 0) begin
         it = q.pop_front();
         for (int k = 0; k < 8; k++) begin
            act = {addr_sel, mar_ld, mem_rd, mem_wr, mdr_ld, acc_ld, alu_op, pc_inc, pc_ld};
            chk("R2", 32'(step), 32'(k), "step count");
            chk(tag_for(it.ib, k), 32'(act), 32'(exp_strb(it.ib, k)),
                $sformatf("strobes op=%02h step=%0d", it.ib, k));
            chk("R12", 32'(mem_rd && mem_wr), 32'd0, "read with write");
            if (it.ib[7:4] == 4'hF && k == 3) begin
               for (int h = 0; h < 4; h++) begin
                  @(negedge clk);
                  act = {addr_sel, mar_ld, mem_rd, mem_wr, mdr_ld, acc_ld, alu_op, pc_inc, pc_ld};
                  chk("R10", 32'(halted), 32'd1, "halted flag");
                  chk("R10", 32'(step), 32'd3, "frozen step");
                  chk("R10", 32'(pc), 32'(it.pc_after), "frozen pc");
                  chk("R10", 32'(act), 32'd0, "strobes while halted");
               end
               break;
            end
            @(negedge clk);
         end
         if (it.ib[7:4] != 4'hF)
            chk("R11", 32'(pc), 32'(it.pc_after), $sformatf("pc after op=%02h", it.ib));
      end
   endtask

   task automatic start_run(input logic neg, input logic zero);
      rst_n = 1'b0;
      flag_neg = neg;
      flag_zero = zero;
      for (int a = 0; a < 256; a++) mem[a] = 8'(a ^ 8'h5A);
      q.delete();
      wp = 8'h00;
      repeat (3) @(negedge clk);
   endtask

   task automatic release_and_check();
      chk("R1", 32'(pc), 32'd0, "pc in reset");
      chk("R1", 32'(step), 32'd0, "step in reset");
      chk("R1", 32'(halted), 32'd0, "halted in reset");
      rst_n = 1'b1;
      chk("R1", 32'(pc), 32'd0, "pc at release");
      run_monitor();
   endtask

   initial begin
      // run A: both flags clear
      start_run(1'b0, 1'b0);
      emit(8'h2A, 8'h40);   // LDA, low nibble nonzero (R4)
      emit(8'h30, 8'h41);   // ADD
      emit(8'h40, 8'h42);   // OR
      emit(8'h50, 8'h43);   // AND
      emit(8'h60, 8'h00);   // NOT
      emit(8'h10, 8'h44);   // STA
      emit(8'h00, 8'h00);   // NOP
      emit(8'h7C, 8'h00);   // undefined code -> NOP (R4)
      emit(8'hC5, 8'h00);   // undefined code -> NOP (R4)
      emit(8'h80, 8'h20);   // JMP
      emit(8'h90, 8'h30);   // JN skipped (R9)
      emit(8'hA0, 8'h30);   // JZ skipped (R9)
      emit(8'hF0, 8'h00);   // HLT
      release_and_check();

      // run B: both flags set
      start_run(1'b1, 1'b1);
      emit(8'h90, 8'h10);   // JN taken (R9)
      emit(8'hA0, 8'h30);   // JZ taken (R9)
      emit(8'h8F, 8'h50);   // JMP with low bits set (R8, R4)
      emit(8'h20, 8'h60);   // LDA
      emit(8'hF3, 8'h00);   // HLT with low bits set (R10)
      release_and_check();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule